// File: doc/BRIEF.md
# Receive Frame Length and Station Address Gate

This block sits in the receive path between the Ethernet MAC byte stream and the receive DMA. Each incoming frame arrives one byte per cycle, with a start marker on its first byte and an end marker on its last. The block measures the frame against a programmed undersize threshold and a maximum payload length. When the unicast check is enabled, it also compares the six-byte destination field with a programmed station address. A frame that fails any check is discarded completely. One of three saturation-free wrap-around drop counters records why it was dropped.

The verdict is only known once the last byte is in. For that reason, every frame is written into an internal store-and-forward buffer first. A frame becomes visible downstream only after it is accepted; a rejected frame is rolled back. Software clears the enable input for promiscuous or all-multicast operation, and then only the length checks apply.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset, `out_valid` is low and all three drop counters read zero.
- R2: The station address is formed as follows. Its first received byte is `cfg_sta_lo[7:0]`, and bytes two to four follow in the higher bytes of `cfg_sta_lo`. The fifth byte is `cfg_sta_hi[23:16]` and the sixth is `cfg_sta_hi[31:24]`. With `filt_en` high, a frame whose first six bytes equal this address is forwarded byte for byte.
- R3: With `filt_en` high, a frame whose destination differs from the station address and whose first byte has bit 0 clear is dropped, and `cnt_mismatch` increases by one.
- R4: With `filt_en` high, a frame whose first byte has bit 0 set (group address) is forwarded whatever its other destination bytes are.
- R5: With `filt_en` low, frames are forwarded regardless of destination, and `cnt_mismatch` does not change.
- R6: A frame whose total byte count is below `cfg_len[31:16]` is dropped and counted in `cnt_undersize`. A frame of exactly that count passes.
- R7: A frame whose total byte count exceeds `cfg_len[15:0]` plus 14 header bytes is dropped and counted in `cnt_oversize`. A frame of exactly that count passes.
- R8: A dropped frame increments exactly one counter. The order of precedence is undersize, then oversize, then address mismatch.
- R9: No byte of a frame leaves before its last byte has been received. Accepted frames leave in arrival order, contiguous, with the start marker on the first byte and the end marker on the last.
- R10: A start marker that arrives inside an unfinished frame discards the partial frame without touching any counter and begins a new frame.
- R11: A frame longer than `BUF_DEPTH-4` bytes is treated as oversize whatever the programmed maximum.
- R12: The drop counters change only in a cycle that carries a frame's end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| cfg_sta_lo | input | 32 | Station address bytes one to four |
| cfg_sta_hi | input | 32 | Station address bytes five and six in bits 31:16 |
| cfg_len | input | 32 | Undersize threshold (31:16), maximum payload (15:0) |
| filt_en | input | 1 | Unicast destination check enable |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | First byte of an accepted frame |
| out_eop | output | 1 | Last byte of an accepted frame |
| out_data | output | 8 | Output byte |
| cnt_undersize | output | CNT_W | Frames dropped as too short |
| cnt_oversize | output | CNT_W | Frames dropped as too long |
| cnt_mismatch | output | CNT_W | Frames dropped on destination mismatch |

## Verification
Some properties are checked on every cycle. The counters stay still except on end-marker cycles. The mismatch counter stays still while the filter is off. The output never opens a second frame before closing the previous one. A buffer write never lands on an unread byte. Other behaviour only the bench scenarios can show. These are the accept or drop decision at exact length boundaries, the precedence among drop reasons, the address byte mapping, the rollback of a frame cut short by a new start marker, and the fact that forwarded bytes match the input.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
   typedef enum logic [1:0] {
      VERD_PASS  = 2'd0,
      VERD_UNDER = 2'd1,
      VERD_OVER  = 2'd2,
      VERD_MISS  = 2'd3
   } verdict_e;

   localparam int HDR_BYTES  = 14;
   localparam int ADDR_BYTES = 6;
endpackage

// File: rtl/rxg_addr_match.sv
module rxg_addr_match
   import rxg_pkg::*;
#(
   parameter int NBYTES = ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              sop,
   input  logic [7:0]        data,
   input  logic [8*NBYTES-1:0] sta,
   input  logic              en,
   output logic              pass
);
   localparam int IW = $clog2(NBYTES + 1);

   logic [7:0]    sta_b [NBYTES];
   logic [IW-1:0] idx, n_idx;
   logic          ok, n_ok, grp, n_grp;

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
         assign sta_b[g] = sta[8*g +: 8];
      end
      if (NBYTES < 1) begin : g_bad
         $error("rxg_addr_match: NBYTES must be positive");
      end
   endgenerate

   always_comb begin
      n_idx = idx;
      n_ok  = ok;
      n_grp = grp;
      if (sop) begin
         n_idx = IW'(1);
         n_ok  = (data == sta_b[0]);
         n_grp = data[0];
      end else if (idx < IW'(NBYTES)) begin
         n_idx = idx + IW'(1);
         n_ok  = ok && (data == sta_b[idx]);
      end
   end

   assign pass = !en || n_grp || ((n_idx == IW'(NBYTES)) && n_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         ok  <= 1'b0;
         grp <= 1'b0;
      end else if (beat) begin
         idx <= n_idx;
         ok  <= n_ok;
         grp <= n_grp;
      end
   end

   assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IW'(NBYTES));
endmodule

// File: rtl/rxg_len_judge.sv
module rxg_len_judge
   import rxg_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int LEN_CAP = 2044
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             sop,
   input  logic             eop,
   input  logic [15:0]      min_len,
   input  logic [15:0]      max_pay,
   input  logic             addr_pass,
   output logic             wr_ok,
   output verdict_e         verdict,
   output logic [CNT_W-1:0] cnt_under,
   output logic [CNT_W-1:0] cnt_over,
   output logic [CNT_W-1:0] cnt_miss
);
   localparam logic [16:0] CAP  = 17'(LEN_CAP);
   localparam logic [16:0] SATV = '1;

   logic [16:0] cnt, n_cnt, lim_raw, lim;
   logic        under, over, fin;

   generate
      if (LEN_CAP < 1 || LEN_CAP > 65535) begin : g_bad
         $error("rxg_len_judge: LEN_CAP out of range");
      end
   endgenerate

   always_comb begin
      if (sop)              n_cnt = 17'd1;
      else if (cnt == SATV) n_cnt = cnt;
      else                  n_cnt = cnt + 17'd1;
      lim_raw = {1'b0, max_pay} + 17'(HDR_BYTES);
      lim     = (lim_raw > CAP) ? CAP : lim_raw;
      under   = n_cnt < {1'b0, min_len};
      over    = n_cnt > lim;
      if (under)           verdict = VERD_UNDER;
      else if (over)       verdict = VERD_OVER;
      else if (!addr_pass) verdict = VERD_MISS;
      else                 verdict = VERD_PASS;
   end

   assign wr_ok = n_cnt <= CAP;
   assign fin   = beat && eop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cnt_under <= '0;
         cnt_over  <= '0;
         cnt_miss  <= '0;
      end else begin
         if (beat) cnt <= n_cnt;
         if (fin) begin
            case (verdict)
               VERD_UNDER: cnt_under <= cnt_under + 1'b1;
               VERD_OVER:  cnt_over  <= cnt_over + 1'b1;
               VERD_MISS:  cnt_miss  <= cnt_miss + 1'b1;
               default:    ;
            endcase
         end
      end
   end

   assert_quiet_between_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable({cnt_under, cnt_over, cnt_miss}));
endmodule

// File: rtl/rxg_commit_fifo.sv
module rxg_commit_fifo #(
   parameter int DEPTH = 2048,
   parameter int W     = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   input  logic         abort,
   output logic         rd_valid,
   output logic [W-1:0] rd_data
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr, cmt, rd, wa;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 16) begin : g_bad
         $error("rxg_commit_fifo: DEPTH must be a power of two of at least 16");
      end
   endgenerate

   assign wa = restart ? cmt : wr;

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr       <= '0;
         cmt      <= '0;
         rd       <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (abort)        wr <= cmt;
         else if (we)      wr <= wa + 1'b1;
         else if (restart) wr <= cmt;
         if (commit) cmt <= we ? wa + 1'b1 : wa;
         if (rd != cmt) begin
            rd_valid <= 1'b1;
            rd_data  <= mem[rd];
            rd       <= rd + 1'b1;
         end else begin
            rd_valid <= 1'b0;
         end
      end
   end

   assert_no_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (wa + 1'b1) != rd);
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
   import rxg_pkg::*;
#(
   parameter int BUF_DEPTH = 2048,
   parameter int CNT_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [7:0]       in_data,
   input  logic [31:0]      cfg_sta_lo,
   input  logic [31:0]      cfg_sta_hi,
   input  logic [31:0]      cfg_len,
   input  logic             filt_en,
   output logic             out_valid,
   output logic             out_sop,
   output logic             out_eop,
   output logic [7:0]       out_data,
   output logic [CNT_W-1:0] cnt_undersize,
   output logic [CNT_W-1:0] cnt_oversize,
   output logic [CNT_W-1:0] cnt_mismatch
);
   localparam int LEN_CAP = BUF_DEPTH - 4;
   localparam int EW      = 10;

   logic           in_frame, beat, fin, addr_ok, wr_ok, we, out_open;
   logic [47:0]    sta;
   logic [EW-1:0]  rd_word;
   verdict_e       verdict;

   generate
      if (CNT_W < 1) begin : g_bad
         $error("rx_frame_gate: CNT_W must be positive");
      end
   endgenerate

   assign sta  = {cfg_sta_hi[31:16], cfg_sta_lo};
   assign beat = in_valid && (in_sop || in_frame);
   assign fin  = beat && in_eop;
   assign we   = beat && wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    in_frame <= 1'b0;
      else if (beat) in_frame <= !in_eop;
   end

   rxg_addr_match #(.NBYTES(ADDR_BYTES)) u_match (
      .clk(clk), .rst_n(rst_n), .beat(beat), .sop(in_sop), .data(in_data),
      .sta(sta), .en(filt_en), .pass(addr_ok)
   );

   rxg_len_judge #(.CNT_W(CNT_W), .LEN_CAP(LEN_CAP)) u_judge (
      .clk(clk), .rst_n(rst_n), .beat(beat), .sop(in_sop), .eop(in_eop),
      .min_len(cfg_len[31:16]), .max_pay(cfg_len[15:0]), .addr_pass(addr_ok),
      .wr_ok(wr_ok), .verdict(verdict),
      .cnt_under(cnt_undersize), .cnt_over(cnt_oversize), .cnt_miss(cnt_mismatch)
   );

   rxg_commit_fifo #(.DEPTH(BUF_DEPTH), .W(EW)) u_buf (
      .clk(clk), .rst_n(rst_n), .restart(beat && in_sop), .we(we),
      .wdata({in_sop, in_eop, in_data}),
      .commit(fin && verdict == VERD_PASS),
      .abort(fin && verdict != VERD_PASS),
      .rd_valid(out_valid), .rd_data(rd_word)
   );

   assign out_sop  = out_valid && rd_word[9];
   assign out_eop  = out_valid && rd_word[8];
   assign out_data = rd_word[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    out_open <= 1'b0;
      else if (out_valid && out_eop) out_open <= 1'b0;
      else if (out_valid && out_sop) out_open <= 1'b1;
   end

   assert_sop_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop) |-> !out_open);
   assert_body_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> out_open);
   assert_filter_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !filt_en |=> $stable(cnt_mismatch));
endmodule

// File: tb/rx_frame_gate_test.sv
module rx_frame_gate_test;
   localparam int DEPTH = 2048;
   localparam logic [47:0] STA = 48'h021122334455;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, filt_en = 1'b1;
   logic [7:0]  in_data = 8'h00;
   logic [31:0] cfg_sta_lo = 32'h33221102, cfg_sta_hi = 32'h55440000;
   logic [31:0] cfg_len = {16'd64, 16'd1500};
   logic        out_valid, out_sop, out_eop;
   logic [7:0]  out_data;
   logic [15:0] cnt_undersize, cnt_oversize, cnt_mismatch;

   int n_chk = 0, n_err = 0, frames_done = 0, fid_next = 0;
   int exp_u = 0, exp_o = 0, exp_m = 0;
   bit finished = 0;
   logic [9:0] exp_q[$];
   int fid_q[$];

   always #4 clk = ~clk;

   rx_frame_gate #(.BUF_DEPTH(DEPTH), .CNT_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .cfg_sta_lo(cfg_sta_lo),
      .cfg_sta_hi(cfg_sta_hi), .cfg_len(cfg_len), .filt_en(filt_en),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_data(out_data), .cnt_undersize(cnt_undersize),
      .cnt_oversize(cnt_oversize), .cnt_mismatch(cnt_mismatch)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops expected bytes as the design emits them (R2, R9)
   always @(negedge clk) begin
      if (rst_n && out_valid && !finished) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9 unexpected output byte", {out_sop, out_eop, out_data}, 0);
         end else begin
            logic [9:0] e;
            int f;
            e = exp_q.pop_front();
            f = fid_q.pop_front();
            chk({out_sop, out_eop, out_data} == e, "R2/R9 output byte",
                {out_sop, out_eop, out_data}, e);
            chk(f < frames_done, "R9 byte left before frame end", f, frames_done);
         end
      end
   end

   // Called at a negedge; returns at the negedge after the last byte is sampled
   task automatic send(input int len, input logic [47:0] dst, input int seed,
                       input bit pass, input bit open_end, input bit hold);
      for (int k = 0; k < len; k++) begin
         logic [7:0] b;
         bit last;
         b = (k < 6) ? dst[47-8*k -: 8] : 8'(seed + k * 7);
         last = (k == len - 1) && !open_end;
         if (pass) begin
            exp_q.push_back({k == 0, last, b});
            fid_q.push_back(fid_next);
         end
         in_valid = 1'b1; in_sop = (k == 0); in_eop = last; in_data = b;
         @(negedge clk);
      end
      fid_next++;
      frames_done = fid_next;
      if (!hold) begin
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
   endtask

   task automatic drain_and_count(input string req);
      for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, {req, " frames delivered"}, exp_q.size(), 0);
      chk(cnt_undersize == 16'(exp_u), {req, " undersize count"}, cnt_undersize, exp_u);
      chk(cnt_oversize == 16'(exp_o), {req, " oversize count"}, cnt_oversize, exp_o);
      chk(cnt_mismatch == 16'(exp_m), {req, " mismatch count"}, cnt_mismatch, exp_m);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk({cnt_undersize, cnt_oversize, cnt_mismatch} == '0, "R1 counters",
          {cnt_undersize, cnt_oversize, cnt_mismatch}, 0);

      // R2, R6: matching frame at exact undersize threshold passes
      send(64, STA, 5, 1, 0, 0);
      drain_and_count("R2 R6 match at minimum");
      // R6: one byte short
      send(63, STA, 9, 0, 0, 0); exp_u++;
      drain_and_count("R6 undersize");
      // R3: unicast mismatch in last address byte
      send(70, 48'h021122334456, 3, 0, 0, 0); exp_m++;
      drain_and_count("R3 mismatch");
      // R4: group bit set passes
      send(80, 48'h03AABBCCDDEE, 11, 1, 0, 0);
      drain_and_count("R4 group");
      // R5: filter off
      filt_en = 1'b0;
      send(70, 48'h0A0B0C0D0E0F, 13, 1, 0, 0);
      drain_and_count("R5 filter off");
      filt_en = 1'b1;
      // R7: maximum payload 100 -> 114 total passes, 115 dropped
      cfg_len = {16'd64, 16'd100};
      send(114, STA, 17, 1, 0, 0);
      send(115, STA, 19, 0, 0, 0); exp_o++;
      drain_and_count("R7 oversize boundary");
      // R8: precedence among drop reasons
      send(40, 48'h020000000000, 21, 0, 0, 0); exp_u++;
      send(200, 48'h020000000000, 23, 0, 0, 0); exp_o++;
      drain_and_count("R8 single reason");
      // R10: partial frame abandoned by a new start marker
      send(20, STA, 25, 0, 1, 0);
      repeat (2) @(negedge clk);
      send(66, STA, 27, 1, 0, 0);
      drain_and_count("R10 restart");
      // R9: back-to-back frames keep order
      send(64, STA, 31, 1, 0, 1);
      send(90, 48'h01FFFFFFFFFF, 33, 1, 0, 1);
      send(65, STA, 35, 1, 0, 0);
      drain_and_count("R9 back to back");
      // R11: buffer capacity limit
      cfg_len = {16'd64, 16'hFFFF};
      send(DEPTH - 3, STA, 37, 0, 0, 0); exp_o++;
      send(DEPTH - 4, STA, 39, 1, 0, 0);
      drain_and_count("R11 capacity");
      // R12: idle input leaves counters unchanged
      repeat (20) @(negedge clk);
      drain_and_count("R12 idle");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (finished) break;
      end
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule